// File: doc/BRIEF.md
# Exception Return Frame Unwinder

This sequencer performs the stack-side work of a return-from-exception instruction. A single `start` pulse hands it the supervisor stack pointer, the status register in force and the address of the return instruction. It then fetches the frame over a 32-bit read port with a request/ready handshake and ends in exactly one of three outcomes: a commit of the restored status register, program counter and popped stack pointer; a format-error request; or an address-error request.

The frame is big-endian. The status word sits at the stack pointer, the 32-bit return address at stack pointer plus 2, and the format/vector word at stack pointer plus 6. With long-word reads this takes two transfers. The long word at SP+4 is fetched first. Its low half is the format word and its high half is the low half of the return address. The long word at SP is fetched second. Its high half is the status word and its low half is the high half of the return address. Every supported frame type goes through the same path. The size of each frame type comes from a byte table given as a parameter.

Top module: `rte_unwind`

## Requirements
- R1: After reset, `busy`, `mem_req`, `done`, `format_fault` and `addr_fault` are all low.
- R2: The first read after an accepted start is at `sp_in + 4`. The format code is bits 15:12 of the low half of that long word.
- R3: Only codes 0, 2 and 4 are valid, with frame sizes of 8, 12 and 16 bytes. Any other code raises `format_fault`, and no second read is made.
- R4: For a valid code, the second read is at `sp_in`. The restored SR is bits 31:16 of that read. The restored PC is {bits 15:0 of the second read, bits 31:16 of the first read}.
- R5: When the valid frame's restored PC has bit 0 set, the block raises `addr_fault` and not `done`. A bad format code wins over an odd PC.
- R6: On success, `done` is raised with `new_sr` and `new_pc` taken from the frame, and `new_sp` = `sp_in` + frame size for that code.
- R7: A `start` that arrives while `busy` is high is ignored. The run in progress completes with its own operands.
- R8: `mem_req` is high only while a read is pending. While `mem_req` is high and `mem_ready` is low, `mem_addr` does not change.
- R9: Each accepted start produces exactly one one-cycle pulse on one of `done`, `format_fault` or `addr_fault`. A `start` given in that pulse cycle is accepted.
- R10: During a fault pulse, `fault_sr` equals the `sr_in` that was latched at start, and `fault_pc` equals the `rte_pc` that was latched at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an unwind (taken only when idle) |
| sp_in | input | 32 | Supervisor stack pointer at start |
| sr_in | input | 16 | Status register at start |
| rte_pc | input | 32 | Address of the return instruction |
| mem_req | output | 1 | Read request |
| mem_addr | output | 32 | Byte address of the long word to read |
| mem_rdata | input | 32 | Read data, big-endian long word |
| mem_ready | input | 1 | Read data valid, ends the transfer |
| busy | output | 1 | Unwind in progress |
| done | output | 1 | One-cycle success pulse |
| new_sr | output | 16 | Restored status register |
| new_pc | output | 32 | Restored program counter |
| new_sp | output | 32 | Stack pointer after the pop |
| format_fault | output | 1 | One-cycle format-error request |
| addr_fault | output | 1 | One-cycle address-error request |
| fault_sr | output | 16 | Status register for the new exception frame |
| fault_pc | output | 32 | Return-instruction address for the new exception |

## Verification
Two events can land in the same cycle: the outcome pulse of one run and the acceptance of the next `start`. The bench drives `start` in the exact cycle in which it sees `done` or a fault pulse. It then checks that `busy` rises in the following cycle and that the second run completes with its own frame. The bench also raises `start` while a run is in its read phase. A correct block then returns results computed only from the first run's frame, and every read stays inside that frame.

// File: rtl/rte_unwind.sv
module rte_unwind #(
  parameter int AW = 32,
  parameter logic [127:0] FMT_BYTES = 128'h0000_0000_0000_0000_0000_0010_000C_0008
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] sp_in,
  input  logic [15:0]   sr_in,
  input  logic [AW-1:0] rte_pc,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ready,
  output logic          busy,
  output logic          done,
  output logic [15:0]   new_sr,
  output logic [31:0]   new_pc,
  output logic [AW-1:0] new_sp,
  output logic          format_fault,
  output logic          addr_fault,
  output logic [15:0]   fault_sr,
  output logic [AW-1:0] fault_pc
);

  typedef enum logic [1:0] {S_IDLE, S_FMT, S_SR} state_t;

  state_t        st;
  logic [AW-1:0] sp_q, rpc_q;
  logic [15:0]   sr_q, pclo_q;
  logic [7:0]    size_q;

  logic [3:0]  fmt_code;
  logic [7:0]  fmt_size;
  logic        fmt_ok;
  logic [31:0] pc_full;

  assign fmt_code = mem_rdata[15:12];
  assign fmt_size = FMT_BYTES[{fmt_code, 3'b000} +: 8];
  assign fmt_ok   = fmt_size != 8'd0;
  assign pc_full  = {mem_rdata[15:0], pclo_q};

  assign busy     = st != S_IDLE;
  assign mem_req  = busy;
  assign mem_addr = (st == S_FMT) ? sp_q + AW'(4) : sp_q;
  assign fault_sr = sr_q;
  assign fault_pc = rpc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      sp_q         <= '0;
      rpc_q        <= '0;
      sr_q         <= '0;
      pclo_q       <= '0;
      size_q       <= '0;
      done         <= 1'b0;
      format_fault <= 1'b0;
      addr_fault   <= 1'b0;
      new_sr       <= '0;
      new_pc       <= '0;
      new_sp       <= '0;
    end else begin
      done         <= 1'b0;
      format_fault <= 1'b0;
      addr_fault   <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          sp_q  <= sp_in;
          sr_q  <= sr_in;
          rpc_q <= rte_pc;
          st    <= S_FMT;
        end
        S_FMT: if (mem_ready) begin
          if (!fmt_ok) begin
            format_fault <= 1'b1;
            st           <= S_IDLE;
          end else begin
            pclo_q <= mem_rdata[31:16];
            size_q <= fmt_size;
            st     <= S_SR;
          end
        end
        S_SR: if (mem_ready) begin
          if (pc_full[0]) begin
            addr_fault <= 1'b1;
          end else begin
            done   <= 1'b1;
            new_sr <= mem_rdata[31:16];
            new_pc <= pc_full;
            new_sp <= sp_q + AW'(size_q);
          end
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !busy && !mem_req && !done && !format_fault && !addr_fault);
  p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({done, format_fault, addr_fault}));
  p_pulse_once_r9:  assert property (@(posedge clk) disable iff (!rst_n) (done || format_fault || addr_fault) |=> !(done || format_fault || addr_fault));
  p_addr_hold_r8:   assert property (@(posedge clk) disable iff (!rst_n) (mem_req && !mem_ready && busy) |=> mem_req && $stable(mem_addr));
  p_even_pc_r6:     assert property (@(posedge clk) disable iff (!rst_n) done |-> !new_pc[0]);
  p_fault_idle_r10: assert property (@(posedge clk) disable iff (!rst_n) (format_fault || addr_fault) |-> $stable(fault_pc) && $stable(fault_sr));

endmodule

// File: tb/tb_rte_unwind.sv
module tb_rte_unwind;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] sp_in = '0, rte_pc = '0;
  logic [15:0] sr_in = '0;
  logic        mem_req, mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic        busy, done, format_fault, addr_fault;
  logic [15:0] new_sr, fault_sr;
  logic [31:0] new_pc, new_sp, fault_pc;

  rte_unwind dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sp_in(sp_in), .sr_in(sr_in), .rte_pc(rte_pc),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .busy(busy), .done(done), .new_sr(new_sr), .new_pc(new_pc), .new_sp(new_sp),
    .format_fault(format_fault), .addr_fault(addr_fault), .fault_sr(fault_sr), .fault_pc(fault_pc)
  );

  always #4 clk = ~clk;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  logic [31:0] cur_sp, cur_rpc, cur_fpc, first_addr;
  logic [15:0] cur_sr, cur_fsr, cur_fw;
  int reads = 0, bad_reads = 0, wait_cnt = 0;

  function automatic logic [31:0] lookup(input logic [31:0] a);
    if (a == cur_sp) return {cur_fsr, cur_fpc[31:16]};
    if (a == cur_sp + 32'd4) return {cur_fpc[15:0], cur_fw};
    bad_reads++;
    return 32'hBAD0_BAD0;
  endfunction

  function automatic int exp_size(input logic [3:0] code);
    case (code)
      4'd0: return 8;
      4'd2: return 12;
      4'd4: return 16;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      mem_ready = 1'b0;
      if (mem_req) begin
        if (wait_cnt == 0) begin
          if (reads == 0) first_addr = mem_addr;
          mem_rdata = lookup(mem_addr);
          mem_ready = 1'b1;
          reads++;
          wait_cnt = $urandom % 3;
        end else wait_cnt--;
      end
    end
  end

  task automatic launch(input logic [31:0] sp, input logic [15:0] sr, input logic [31:0] rpc,
                        input logic [15:0] fsr, input logic [31:0] fpc, input logic [15:0] fw);
    cur_sp = sp; cur_sr = sr; cur_rpc = rpc; cur_fsr = fsr; cur_fpc = fpc; cur_fw = fw;
    reads = 0; bad_reads = 0;
    sp_in = sp; sr_in = sr; rte_pc = rpc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_check(input bit poke);
    int n = 0;
    bit seen = 0;
    if (poke) begin
      sp_in = cur_sp + 32'h100; sr_in = ~cur_sr; rte_pc = cur_rpc + 32'h40; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R7 busy during ignored start", 32'(busy || done || format_fault || addr_fault), 32'd1);
    end
    while (!seen && n < 100) begin
      if (done || format_fault || addr_fault) seen = 1;
      else begin @(negedge clk); n++; end
    end
    chk("R9 outcome pulse seen", 32'(seen), 32'd1);
    begin
      int sz = exp_size(cur_fw[15:12]);
      bit ef = (sz == 0);
      bit ea = !ef && cur_fpc[0];
      bit ed = !ef && !ea;
      chk("R2 first read address", first_addr, cur_sp + 32'd4);
      chk("R7 no stray reads", 32'(bad_reads), 32'd0);
      chk(ef ? "R3 format fault" : "R3 no format fault", 32'(format_fault), 32'(ef));
      chk(ea ? "R5 address fault" : "R5 no address fault", 32'(addr_fault), 32'(ea));
      chk("R6 done flag", 32'(done), 32'(ed));
      chk(ef ? "R3 read count" : "R4 read count", 32'(reads), ef ? 32'd1 : 32'd2);
      if (ed) begin
        chk("R4 new_sr", 32'(new_sr), 32'(cur_fsr));
        chk("R4 new_pc", new_pc, cur_fpc);
        chk("R6 new_sp", new_sp, cur_sp + 32'(sz));
      end else begin
        chk("R10 fault_sr", 32'(fault_sr), 32'(cur_sr));
        chk("R10 fault_pc", fault_pc, cur_rpc);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 busy after reset", 32'(busy), 32'd0);
    chk("R1 mem_req after reset", 32'(mem_req), 32'd0);
    chk("R1 pulses after reset", 32'({done, format_fault, addr_fault}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    launch(32'h0000_1000, 16'h2700, 32'h0000_4000, 16'h0004, 32'h0001_2344, 16'h0064); finish_check(0); // R6 code 0
    launch(32'h0000_2000, 16'h2000, 32'h0000_4100, 16'h0010, 32'h0002_0000, 16'h2008); finish_check(0); // R6 code 2
    launch(32'h0000_3002, 16'h2100, 32'h0000_4200, 16'h0000, 32'h8000_0010, 16'h4008); finish_check(0); // R6 code 4
    launch(32'h0000_5000, 16'h2300, 32'h0000_4300, 16'hFFFF, 32'h0000_0101, 16'h0018); finish_check(0); // R5 odd pc
    launch(32'h0000_6000, 16'h2400, 32'h0000_4400, 16'h1111, 32'h0000_0301, 16'h7018); finish_check(0); // R3/R5 precedence
    launch(32'h0000_7000, 16'h2500, 32'h0000_4500, 16'h2222, 32'h0000_0400, 16'hF000); finish_check(0); // R3 code F
    launch(32'h0000_8000, 16'h2600, 32'h0000_4600, 16'h3333, 32'h0000_0500, 16'h0000); finish_check(1); // R7
    // R9: new start in the pulse cycle
    launch(32'h0000_9000, 16'h2000, 32'h0000_4700, 16'h4444, 32'h0000_0600, 16'h2000);
    finish_check(0);
    launch(32'h0000_A000, 16'h2100, 32'h0000_4800, 16'h5555, 32'h0000_0700, 16'h4000);
    chk("R9 start in pulse cycle accepted", 32'(busy), 32'd1);
    finish_check(0);

    for (int i = 0; i < 60; i++) begin
      logic [3:0] code;
      int pick = $urandom % 8;
      code = (pick < 2) ? 4'd0 : (pick < 4) ? 4'd2 : (pick < 6) ? 4'd4 : 4'($urandom);
      @(negedge clk);
      launch({$urandom, 1'b0} & 32'hFFFF_FFF0 | 32'(($urandom % 4) * 2), 16'($urandom), {$urandom} & 32'hFFFF_FFFE,
             16'($urandom), ($urandom % 4 == 0) ? ({$urandom} | 32'd1) : ({$urandom} & 32'hFFFF_FFFE),
             {code, 12'($urandom)});
      finish_check(i % 7 == 3);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule